// File: doc/BRIEF.md
# Configuration bitfile header unwrapper

This block sits between a byte source, such as a flash reader, and the loader of a programmable-logic configuration port. It takes a stored configuration file one byte per cycle over a valid/ready stream and finds the raw configuration payload inside it. A wrapped file opens with a fixed 13-byte signature. After the signature comes a chain of tagged sections, each made of a one-byte tag, a big-endian length and that many content bytes. The unwrapper walks this chain and discards every section except the payload section. It forwards the payload bytes on an output stream. Next to each output byte it presents the decoded payload length and a flag that tells a wrapped image from a legacy one.

Older images carry no wrapper. Such an image opens with two 32-bit marker words stored little-endian, and the unwrapper recognises it from them. It then forwards a fixed number of words, swapping the byte order inside each 4-byte group, because the stored words are little-endian but must be shifted out most significant byte first.

The unwrapper reports malformed input with a one-cycle error pulse and a cause code. After a file ends or fails, it discards input up to the byte marked last. The byte after that starts a new file.

Top module: `bitfile_unwrap`

## Requirements
- R1: Straight after reset `in_ready` is 1, `out_valid` is 0 and `err_pulse` is 0.
- R2: A wrapped file must open with 00 09 0F F0 0F F0 0F F0 0F F0 00 00 01. Any other opening that is not the legacy marker raises `err_pulse` with `err_code` 1 and forwards nothing.
- R3: A section tag is an ASCII byte from 'a' (0x61) to 'e' (0x65). Any other tag raises `err_pulse` with `err_code` 2.
- R4: The length after tag 'e' is 4 bytes and every other tag has a 2-byte length, both most significant byte first. A non-'e' length above 255 raises `err_pulse` with `err_code` 3. A length of exactly 255 is accepted, and an 'e' length above 255 is accepted.
- R5: A section with a tag from 'a' to 'd' is discarded by consuming exactly its length in content bytes, and that length may be zero. Parsing then resumes at the next tag.
- R6: The content bytes of section 'e' appear on `out_data` in order. `out_last` is 1 on the final byte, `pay_len` holds the decoded length and stays stable while the payload streams, and `pay_legacy` is 0. An 'e' section of length zero produces no output and no error.
- R7: A file opening with FF FF FF FF 66 55 99 AA is a legacy image. The block forwards `LEGACY_WORDS`*4 bytes, including the marker, with `pay_legacy` 1 and `pay_len` equal to `LEGACY_WORDS`*4. A file that matches this marker only in part raises `err_code` 1.
- R8: In a legacy image each group of four input bytes b0 b1 b2 b3 is emitted as b3 b2 b1 b0, so the marker comes out as FF FF FF FF AA 99 55 66. While a legacy word is being emitted, `in_ready` is 0.
- R9: If the byte marked `in_last` arrives before the payload is complete, the block raises `err_pulse` with `err_code` 0. It never asserts `out_last` for that file.
- R10: After a payload completes or an error is reported, the block discards input bytes up to and including the one marked `in_last`. The next byte starts a new file.
- R11: While `out_valid` is 1 and `out_ready` is 0, `out_valid` and `out_data` hold. During a wrapped payload, `in_ready` follows `out_ready`.
- R12: `err_pulse` lasts one cycle, comes in the cycle after the offending byte is accepted, and is never high while `out_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted when high with in_valid |
| in_data | input | 8 | Input file byte |
| in_last | input | 1 | Marks the final byte of the file |
| out_valid | output | 1 | Payload byte valid |
| out_ready | input | 1 | Downstream accepts payload byte |
| out_data | output | 8 | Payload byte |
| out_last | output | 1 | Final payload byte |
| pay_len | output | LEN_W | Payload length in bytes, meaningful with out_valid |
| pay_legacy | output | 1 | Payload comes from a legacy image |
| err_pulse | output | 1 | One-cycle malformed-input indication |
| err_code | output | 2 | Cause with err_pulse: 0 truncated, 1 bad signature, 2 bad tag, 3 bad length |

## Verification
The hold check on `out_data` assumes that the byte source behaves like a proper stream. Once it raises `in_valid`, it keeps `in_data` and `in_last` unchanged until the byte is accepted, because during a wrapped payload the output byte is the input byte. The bench drives every byte from a single task that holds all three signals until it sees `in_ready` at a falling edge. It varies `out_ready` only just after a rising edge. As a result, stalls come only from downstream backpressure and never from a source that changes its mind.

// File: rtl/bfu_pkg.sv
package bfu_pkg;

   localparam int SIG_BYTES = 13;
   localparam int MARK_BYTES = 8;

   typedef enum logic [2:0] {
      ST_SIG,
      ST_TAG,
      ST_LEN,
      ST_SKIP,
      ST_PAY,
      ST_LFILL,
      ST_LEMIT,
      ST_DRAIN
   } state_t;

   localparam logic [1:0] ERR_TRUNC = 2'd0;
   localparam logic [1:0] ERR_SIG   = 2'd1;
   localparam logic [1:0] ERR_TAG   = 2'd2;
   localparam logic [1:0] ERR_LEN   = 2'd3;

   localparam logic [7:0] TAG_LO  = 8'h61;
   localparam logic [7:0] TAG_HI  = 8'h65;
   localparam logic [7:0] TAG_PAY = 8'h65;

   // Expected byte of the wrapped-file signature at a given position
   function automatic logic [7:0] sig_byte(input logic [3:0] i);
      case (i)
         4'd1:                      return 8'h09;
         4'd2, 4'd4, 4'd6, 4'd8:    return 8'h0F;
         4'd3, 4'd5, 4'd7, 4'd9:    return 8'hF0;
         4'd12:                     return 8'h01;
         default:                   return 8'h00;
      endcase
   endfunction

   // Expected byte of the legacy marker (two little-endian words)
   function automatic logic [7:0] mark_byte(input logic [3:0] i);
      case (i)
         4'd4:    return 8'h66;
         4'd5:    return 8'h55;
         4'd6:    return 8'h99;
         4'd7:    return 8'hAA;
         default: return 8'hFF;
      endcase
   endfunction

endpackage

// File: rtl/bfu_magic_match.sv
module bfu_magic_match
   import bfu_pkg::*;
(
   input  logic [3:0] pos,
   input  logic [7:0] data,
   output logic       sig_hit,
   output logic       mark_hit
);

   always_comb begin
      sig_hit  = (pos < 4'(SIG_BYTES)) && (data == sig_byte(pos));
      mark_hit = (pos < 4'(MARK_BYTES)) && (data == mark_byte(pos));
   end

endmodule

// File: rtl/bfu_word_pick.sv
module bfu_word_pick #(
   parameter bit SWAP = 1'b1
) (
   input  logic [31:0] word,
   input  logic [1:0]  sel,
   output logic [7:0]  byte_o
);

   generate
      if (SWAP) begin : g_swap
         always_comb byte_o = word[(2'd3 - sel)*8 +: 8];
      end else begin : g_straight
         always_comb byte_o = word[sel*8 +: 8];
      end
   endgenerate

endmodule

// File: rtl/bitfile_unwrap.sv
module bitfile_unwrap
   import bfu_pkg::*;
#(
   parameter int LEN_W        = 32,
   parameter int LEGACY_WORDS = 10524,
   parameter bit SWAP_LEGACY  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic [7:0]       in_data,
   input  logic             in_last,
   output logic             out_valid,
   input  logic             out_ready,
   output logic [7:0]       out_data,
   output logic             out_last,
   output logic [LEN_W-1:0] pay_len,
   output logic             pay_legacy,
   output logic             err_pulse,
   output logic [1:0]       err_code
);

   localparam int WC_W = $clog2(LEGACY_WORDS + 1);
   localparam logic [LEN_W-1:0] LEG_BYTES = LEN_W'(LEGACY_WORDS * 4);
   localparam logic [LEN_W-1:0] SHORT_MAX = LEN_W'(255);

   generate
      if (LEN_W < 32) begin : g_bad_len_w
         $error("LEN_W must hold a 4-byte length");
      end
      if (LEGACY_WORDS < 3) begin : g_bad_words
         $error("LEGACY_WORDS must be at least 3");
      end
   endgenerate

   state_t           state;
   logic [3:0]       idx;
   logic             sig_ok, mark_ok;
   logic             is_pay_tag;
   logic [LEN_W-1:0] len_acc, remain;
   logic [31:0]      wbuf;
   logic [1:0]       emit_idx;
   logic             pre_word, seen_last;
   logic [WC_W-1:0]  words_left;

   logic             sig_hit, mark_hit, hs, hm, acc;
   logic [7:0]       pick_byte;
   logic [LEN_W-1:0] len_next;
   logic [3:0]       len_end;

   bfu_magic_match i_match (
      .pos      (idx),
      .data     (in_data),
      .sig_hit  (sig_hit),
      .mark_hit (mark_hit)
   );

   bfu_word_pick #(.SWAP(SWAP_LEGACY)) i_pick (
      .word   (wbuf),
      .sel    (emit_idx),
      .byte_o (pick_byte)
   );

   always_comb begin
      hs       = sig_ok & sig_hit;
      hm       = mark_ok & mark_hit;
      len_next = {len_acc[LEN_W-9:0], in_data};
      len_end  = is_pay_tag ? 4'd3 : 4'd1;
   end

   // Stream side of the handshake
   always_comb begin
      in_ready  = 1'b1;
      out_valid = 1'b0;
      out_data  = pick_byte;
      out_last  = 1'b0;
      case (state)
         ST_PAY: begin
            in_ready  = out_ready;
            out_valid = in_valid;
            out_data  = in_data;
            out_last  = (remain == LEN_W'(1));
         end
         ST_LEMIT: begin
            in_ready  = 1'b0;
            out_valid = 1'b1;
            out_data  = pre_word ? 8'hFF : pick_byte;
            out_last  = !pre_word && (words_left == WC_W'(1)) && (emit_idx == 2'd3);
         end
         default: ;
      endcase
      acc = in_valid & in_ready;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state      <= ST_SIG;
         idx        <= '0;
         sig_ok     <= 1'b1;
         mark_ok    <= 1'b1;
         is_pay_tag <= 1'b0;
         len_acc    <= '0;
         remain     <= '0;
         wbuf       <= '0;
         emit_idx   <= '0;
         pre_word   <= 1'b0;
         seen_last  <= 1'b0;
         words_left <= '0;
         pay_len    <= '0;
         pay_legacy <= 1'b0;
         err_pulse  <= 1'b0;
         err_code   <= '0;
      end else begin
         err_pulse <= 1'b0;
         case (state)
            ST_SIG: if (acc) begin
               wbuf[idx[1:0]*8 +: 8] <= in_data;
               sig_ok  <= hs;
               mark_ok <= hm;
               idx     <= idx + 4'd1;
               if (in_last || (!hs && !hm) || (hm && idx == 4'd7)
                   || (hs && idx == 4'(SIG_BYTES - 1))) begin
                  idx     <= '0;
                  sig_ok  <= 1'b1;
                  mark_ok <= 1'b1;
               end
               if (in_last) begin
                  err_pulse <= 1'b1;
                  err_code  <= (!hs && !hm) ? ERR_SIG : ERR_TRUNC;
               end else if (!hs && !hm) begin
                  err_pulse <= 1'b1;
                  err_code  <= ERR_SIG;
                  state     <= ST_DRAIN;
               end else if (hm && idx == 4'd7) begin
                  state      <= ST_LEMIT;
                  pre_word   <= 1'b1;
                  emit_idx   <= '0;
                  seen_last  <= 1'b0;
                  words_left <= WC_W'(LEGACY_WORDS);
                  pay_len    <= LEG_BYTES;
                  pay_legacy <= 1'b1;
               end else if (hs && idx == 4'(SIG_BYTES - 1)) begin
                  state <= ST_TAG;
               end
            end
            ST_TAG: if (acc) begin
               if (in_last) begin
                  err_pulse <= 1'b1;
                  err_code  <= ERR_TRUNC;
                  state     <= ST_SIG;
               end else if (in_data < TAG_LO || in_data > TAG_HI) begin
                  err_pulse <= 1'b1;
                  err_code  <= ERR_TAG;
                  state     <= ST_DRAIN;
               end else begin
                  is_pay_tag <= (in_data == TAG_PAY);
                  len_acc    <= '0;
                  idx        <= '0;
                  state      <= ST_LEN;
               end
            end
            ST_LEN: if (acc) begin
               len_acc <= len_next;
               idx     <= idx + 4'd1;
               if (in_last) begin
                  idx       <= '0;
                  err_pulse <= 1'b1;
                  err_code  <= ERR_TRUNC;
                  state     <= ST_SIG;
               end else if (idx == len_end) begin
                  idx <= '0;
                  if (!is_pay_tag && len_next > SHORT_MAX) begin
                     err_pulse <= 1'b1;
                     err_code  <= ERR_LEN;
                     state     <= ST_DRAIN;
                  end else if (len_next == '0) begin
                     state <= is_pay_tag ? ST_DRAIN : ST_TAG;
                  end else begin
                     remain <= len_next;
                     if (is_pay_tag) begin
                        pay_len    <= len_next;
                        pay_legacy <= 1'b0;
                        state      <= ST_PAY;
                     end else begin
                        state <= ST_SKIP;
                     end
                  end
               end
            end
            ST_SKIP: if (acc) begin
               remain <= remain - LEN_W'(1);
               if (in_last) begin
                  err_pulse <= 1'b1;
                  err_code  <= ERR_TRUNC;
                  state     <= ST_SIG;
               end else if (remain == LEN_W'(1)) begin
                  state <= ST_TAG;
               end
            end
            ST_PAY: if (acc) begin
               remain <= remain - LEN_W'(1);
               if (remain == LEN_W'(1)) begin
                  state <= in_last ? ST_SIG : ST_DRAIN;
               end else if (in_last) begin
                  err_pulse <= 1'b1;
                  err_code  <= ERR_TRUNC;
                  state     <= ST_SIG;
               end
            end
            ST_LFILL: if (acc) begin
               wbuf[idx[1:0]*8 +: 8] <= in_data;
               idx <= idx + 4'd1;
               if (idx == 4'd3) begin
                  idx      <= '0;
                  emit_idx <= '0;
                  if (in_last && words_left != WC_W'(1)) begin
                     err_pulse <= 1'b1;
                     err_code  <= ERR_TRUNC;
                     state     <= ST_SIG;
                  end else begin
                     seen_last <= in_last;
                     state     <= ST_LEMIT;
                  end
               end else if (in_last) begin
                  idx       <= '0;
                  err_pulse <= 1'b1;
                  err_code  <= ERR_TRUNC;
                  state     <= ST_SIG;
               end
            end
            ST_LEMIT: if (out_ready) begin
               emit_idx <= emit_idx + 2'd1;
               if (emit_idx == 2'd3) begin
                  words_left <= words_left - WC_W'(1);
                  if (pre_word) begin
                     pre_word <= 1'b0;
                  end else if (words_left == WC_W'(1)) begin
                     state <= seen_last ? ST_SIG : ST_DRAIN;
                  end else begin
                     idx   <= '0;
                     state <= ST_LFILL;
                  end
               end
            end
            ST_DRAIN: if (acc && in_last) begin
               state <= ST_SIG;
            end
            default: state <= ST_SIG;
         endcase
      end
   end

endmodule

// File: rtl/bitfile_unwrap_chk.sv
module bitfile_unwrap_chk #(
   parameter int LEN_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_ready,
   input logic             out_valid,
   input logic             out_ready,
   input logic [7:0]       out_data,
   input logic             out_last,
   input logic [LEN_W-1:0] pay_len,
   input logic             pay_legacy,
   input logic             err_pulse
);

   // R1
   reset_state_chk: assert property (@(posedge clk)
      $rose(rst_n) |-> (!out_valid && in_ready && !err_pulse));

   // R11
   out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

   // R6
   end_of_payload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ready && out_last) |=> !out_valid);

   // R6
   len_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && $past(out_valid)) |-> $stable(pay_len));

   // R8
   legacy_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && pay_legacy) |-> !in_ready);

   // R12
   err_not_with_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_pulse |-> !out_valid);

endmodule

bind bitfile_unwrap bitfile_unwrap_chk #(.LEN_W(LEN_W)) i_chk (.*);

// File: tb/test_bitfile_unwrap.sv
module test_bitfile_unwrap;

   localparam int LEN_W = 32;
   localparam int LW    = 6;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             in_valid = 1'b0;
   logic             in_ready;
   logic [7:0]       in_data = '0;
   logic             in_last = 1'b0;
   logic             out_valid;
   logic             out_ready = 1'b1;
   logic [7:0]       out_data;
   logic             out_last;
   logic [LEN_W-1:0] pay_len;
   logic             pay_legacy;
   logic             err_pulse;
   logic [1:0]       err_code;

   bitfile_unwrap #(.LEN_W(LEN_W), .LEGACY_WORDS(LW)) i_bitfile_unwrap (.*);

   always #5 clk = ~clk;

   int n_tests = 0;
   int n_fail  = 0;
   logic [7:0] tx_q[$];
   logic [7:0] exp_q[$];
   logic [7:0] got_q[$];
   int n_last, last_at, n_err;
   logic [1:0] err_seen;
   logic [LEN_W-1:0] len_seen;
   logic leg_seen;
   logic bp_on = 1'b0;
   int cyc = 0;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      out_ready <= bp_on ? ((cyc % 3) != 0) : 1'b1;
   end

   always @(negedge clk) if (rst_n) begin
      if (out_valid && out_ready) begin
         if (out_last) begin
            n_last++;
            last_at = got_q.size();
         end
         got_q.push_back(out_data);
         len_seen = pay_len;
         leg_seen = pay_legacy;
      end
      if (err_pulse) begin
         n_err++;
         err_seen = err_code;
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic check_payload(input string req);
      int bad = 0;
      check(req, got_q.size(), exp_q.size());
      foreach (exp_q[i]) if (i < got_q.size() && got_q[i] !== exp_q[i]) bad++;
      check(req, bad, 0);
   endtask

   task automatic clr();
      got_q.delete(); exp_q.delete(); tx_q.delete();
      n_last = 0; last_at = -1; n_err = 0; err_seen = 2'bxx;
   endtask

   task automatic send_byte(input logic [7:0] b, input logic last);
      in_data = b; in_last = last; in_valid = 1'b1;
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      in_valid = 1'b0; in_last = 1'b0;
   endtask

   task automatic send_all();
      for (int i = 0; i < tx_q.size(); i++) send_byte(tx_q[i], i == tx_q.size() - 1);
      repeat (60) @(negedge clk);
   endtask

   task automatic put_sig();
      logic [7:0] s[13] = '{8'h00, 8'h09, 8'h0F, 8'hF0, 8'h0F, 8'hF0, 8'h0F,
                            8'hF0, 8'h0F, 8'hF0, 8'h00, 8'h00, 8'h01};
      foreach (s[i]) tx_q.push_back(s[i]);
   endtask

   task automatic put_mark();
      logic [7:0] m[8] = '{8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'h66, 8'h55, 8'h99, 8'hAA};
      foreach (m[i]) tx_q.push_back(m[i]);
   endtask

   task automatic t_reset();
      check("R1 in_ready", in_ready, 1);
      check("R1 out_valid", out_valid, 0);
      check("R1 err_pulse", err_pulse, 0);
   endtask

   task automatic t_basic();
      clr();
      put_sig();
      tx_q.push_back("a"); tx_q.push_back(0); tx_q.push_back(3);
      tx_q.push_back("x"); tx_q.push_back("y"); tx_q.push_back("z");
      tx_q.push_back("b"); tx_q.push_back(0); tx_q.push_back(0);
      tx_q.push_back("c"); tx_q.push_back(0); tx_q.push_back(8'hFF);
      for (int i = 0; i < 255; i++) tx_q.push_back(8'(i));
      tx_q.push_back("e");
      tx_q.push_back(0); tx_q.push_back(0); tx_q.push_back(0); tx_q.push_back(5);
      for (int i = 0; i < 5; i++) begin
         tx_q.push_back(8'h30 + 8'(i)); exp_q.push_back(8'h30 + 8'(i));
      end
      send_all();
      check_payload("R5 R6 payload after skipped sections");
      check("R6 single last", n_last, 1);
      check("R6 last on final byte", last_at, 4);
      check("R6 pay_len", len_seen, 5);
      check("R6 pay_legacy", leg_seen, 0);
      check("R4 len 255 accepted, R2 no error", n_err, 0);
   endtask

   task automatic t_bp_drain();
      clr();
      bp_on = 1'b1;
      put_sig();
      tx_q.push_back("e");
      tx_q.push_back(0); tx_q.push_back(0); tx_q.push_back(1); tx_q.push_back(4);
      for (int i = 0; i < 260; i++) begin
         tx_q.push_back(8'(i * 7)); exp_q.push_back(8'(i * 7));
      end
      tx_q.push_back(8'h11); tx_q.push_back("f"); tx_q.push_back(8'h22);
      send_all();
      check("R11 pay_len 260 under backpressure", len_seen, 260);
      tx_q.delete();
      put_sig();
      tx_q.push_back("d"); tx_q.push_back(0); tx_q.push_back(1); tx_q.push_back("q");
      tx_q.push_back("e");
      tx_q.push_back(0); tx_q.push_back(0); tx_q.push_back(0); tx_q.push_back(2);
      tx_q.push_back(8'hAB); tx_q.push_back(8'hCD);
      exp_q.push_back(8'hAB); exp_q.push_back(8'hCD);
      send_all();
      bp_on = 1'b0;
      check_payload("R10 R11 two files with trailing bytes");
      check("R10 two last flags", n_last, 2);
      check("R4 R10 second pay_len", len_seen, 2);
      check("R10 no error from trailing bytes", n_err, 0);
   endtask

   task automatic t_bad_sig();
      clr();
      put_sig();
      tx_q[9] = 8'hF1;
      for (int i = 0; i < 5; i++) tx_q.push_back(8'h00);
      send_all();
      check("R2 bad signature error count", n_err, 1);
      check("R2 bad signature code", err_seen, 1);
      check("R2 nothing forwarded", got_q.size(), 0);
   endtask

   task automatic t_bad_tag();
      clr();
      put_sig();
      tx_q.push_back("f"); tx_q.push_back(0); tx_q.push_back(1);
      send_all();
      check("R3 tag f error count", n_err, 1);
      check("R3 tag f code", err_seen, 2);
      clr();
      put_sig();
      tx_q.push_back(8'h60); tx_q.push_back(0);
      send_all();
      check("R3 tag below a code", err_seen, 2);
   endtask

   task automatic t_bad_len();
      clr();
      put_sig();
      tx_q.push_back("a"); tx_q.push_back(1); tx_q.push_back(0); tx_q.push_back(0);
      send_all();
      check("R4 length 256 error count", n_err, 1);
      check("R4 length 256 code", err_seen, 3);
   endtask

   task automatic t_trunc();
      clr();
      put_sig();
      tx_q.push_back("b"); tx_q.push_back(0); tx_q.push_back(16);
      for (int i = 0; i < 4; i++) tx_q.push_back(8'(i));
      send_all();
      check("R9 truncated skip code", err_seen, 0);
      check("R9 truncated skip count", n_err, 1);
      check("R9 truncated skip no output", got_q.size(), 0);
      clr();
      put_sig();
      tx_q.push_back("e");
      tx_q.push_back(0); tx_q.push_back(0); tx_q.push_back(0); tx_q.push_back(8);
      for (int i = 0; i < 3; i++) begin
         tx_q.push_back(8'h50 + 8'(i)); exp_q.push_back(8'h50 + 8'(i));
      end
      send_all();
      check_payload("R9 truncated payload bytes");
      check("R9 truncated payload no last", n_last, 0);
      check("R9 truncated payload code", err_seen, 0);
      check("R12 one pulse", n_err, 1);
   endtask

   task automatic t_zero_pay();
      clr();
      put_sig();
      tx_q.push_back("e");
      tx_q.push_back(0); tx_q.push_back(0); tx_q.push_back(0); tx_q.push_back(0);
      tx_q.push_back(8'h77);
      send_all();
      check("R6 zero length no output", got_q.size(), 0);
      check("R6 zero length no error", n_err, 0);
   endtask

   task automatic t_legacy();
      clr();
      put_mark();
      exp_q = '{8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hAA, 8'h99, 8'h55, 8'h66};
      for (int w = 0; w < LW - 2; w++) begin
         for (int b = 0; b < 4; b++) tx_q.push_back(8'(16 * w + b));
         for (int b = 3; b >= 0; b--) exp_q.push_back(8'(16 * w + b));
      end
      send_all();
      check_payload("R7 R8 legacy reversed words");
      check("R7 legacy pay_len", len_seen, LW * 4);
      check("R7 legacy flag", leg_seen, 1);
      check("R8 legacy last on final byte", last_at, LW * 4 - 1);
      check("R7 legacy no error", n_err, 0);
   endtask

   task automatic t_legacy_bad();
      clr();
      put_mark();
      tx_q.pop_back(); tx_q.push_back(8'hAB);
      for (int i = 0; i < 8; i++) tx_q.push_back(8'h00);
      send_all();
      check("R7 partial marker code", err_seen, 1);
      check("R7 partial marker no output", got_q.size(), 0);
      clr();
      put_mark();
      for (int i = 0; i < 5; i++) tx_q.push_back(8'(i));
      send_all();
      check("R9 legacy truncated code", err_seen, 0);
      check("R9 legacy truncated no last", n_last, 0);
   endtask

   logic finished = 1'b0;

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_basic();
      t_bp_drain();
      t_bad_sig();
      t_bad_tag();
      t_bad_len();
      t_trunc();
      t_zero_pay();
      t_legacy();
      t_legacy_bad();
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule